// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

This block collects a small group of peripheral interrupt requests into one sticky status bit per source and drives a single level-sensitive interrupt line toward a parent controller. All control and status sits in one 32-bit register. Each source has an enable bit in the low half of the register. Its status bit sits exactly 16 positions higher. A rising edge on a request input sets the status bit. Software clears a status bit by writing one to it.

Two parameters set which register bits a variant uses: the bit position of the first source and the number of sources. With these, one module covers a seven-source layout starting at bit 0, a six-source layout starting at bit 0 and a two-source layout starting at bit 4. The register port is a plain write strobe with write data and a read-data bus that always shows the current register value.

Software brings the block up by writing ones to every status bit and zeros to every enable bit. After that it services pending sources in ascending bit order. To clear one source it writes that source's status bit as one. It must keep the enables it wants and write zeros to the other status bits, so that no other pending event is lost.

Top module: `irq_agg`

## Requirements
- R1: After reset every enable and status bit reads as zero and `irq_out` is low.
- R2: Source i has its enable at register bit FIRST_BIT+i. Each write loads every configured enable from the write data. Without a write, the enables hold their value.
- R3: A low-to-high change on `src_req[i]` sets the status bit at register bit FIRST_BIT+16+i. The bit reads as one in the cycle after the clock edge that sampled the new high level. A request held high does not set the bit again after a clear.
- R4: A write with a one in a status bit position clears that status bit.
- R5: A write with a zero in a status bit position leaves that status bit unchanged, so a write meant only to change enables keeps all pending events.
- R6: When a rising request and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: `irq_out` is high exactly when at least one source has both its status and its enable bit set. It falls as soon as the last such source is cleared or disabled.
- R8: Status bits latch while their source is disabled. Enabling a source whose status is already set raises `irq_out` in the cycle after that write.
- R9: Register bits outside the configured enable and status fields always read as zero, and writes to them have no effect.
- R10: With FIRST_BIT = 4 and two sources, source 0 uses enable bit 4 and status bit 20, and source 1 uses enable bit 5 and status bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Interrupt request from each source; a rising edge records an event |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data: enables in the low half, clear-on-one status in the high half |
| rd_data | output | 32 | Current register value |
| irq_out | output | 1 | Combined level interrupt to the parent controller |

## Verification
The bound checker checks these rules on every cycle, bit by bit: an edge sets its status bit, a written one clears it, a written zero keeps it, enables load on a write and hold without one, unused bits read zero, and the output level matches the read-back enable and status fields. Some behaviour needs a planned sequence and only the bench can show it. This includes an edge meeting a clear in the same cycle, a held request that must not set its bit again after a clear, and an event latched while disabled that raises the output once it is enabled. The mapping of sources to bits under a non-zero first bit position is also shown only by the bench. A random phase compares the whole register and the output every cycle against a model built from the requirements.

// File: rtl/irqa_pkg.sv
`timescale 1ns/1ps
package irqa_pkg;
   localparam int REG_W    = 32;
   localparam int HALF_W   = 16;
   localparam int STAT_OFS = 16;

   // Mask with n ones starting at bit lo
   function automatic logic [REG_W-1:0] field_mask(input int lo, input int n);
      logic [REG_W-1:0] m;
      m = '0;
      for (int k = 0; k < REG_W; k++) begin
         m[k] = (k >= lo) && (k < lo + n);
      end
      return m;
   endfunction
endpackage

// File: rtl/irqa_edge.sv
`timescale 1ns/1ps
module irqa_edge #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= req;
   end

   assign rise = req & ~prev_q;
endmodule

// File: rtl/irqa_slot.sv
`timescale 1ns/1ps
module irqa_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_en_bit,
   input  logic wr_clr_bit,
   input  logic set,
   output logic en_q,
   output logic st_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         st_q <= 1'b0;
      end else begin
         if (wr_en) en_q <= wr_en_bit;
         // hardware set has priority over a write-one clear
         if (set)                     st_q <= 1'b1;
         else if (wr_en && wr_clr_bit) st_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irqa_pack.sv
`timescale 1ns/1ps
module irqa_pack #(
   parameter int FIRST_BIT = 0,
   parameter int NUM_SRC   = 7
) (
   input  logic [NUM_SRC-1:0]         en,
   input  logic [NUM_SRC-1:0]         st,
   output logic [irqa_pkg::REG_W-1:0] rd,
   output logic                       irq
);
   localparam int STAT_BIT = FIRST_BIT + irqa_pkg::STAT_OFS;

   always_comb begin
      rd = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         rd[FIRST_BIT + i] = en[i];
         rd[STAT_BIT + i]  = st[i];
      end
   end

   assign irq = |(en & st);
endmodule

// File: rtl/irq_agg.sv
`timescale 1ns/1ps
module irq_agg #(
   parameter int FIRST_BIT = 0,
   parameter int NUM_SRC   = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_req,
   input  logic                 wr_en,
   input  logic [31:0]          wr_data,
   output logic [31:0]          rd_data,
   output logic                 irq_out
);
   localparam int STAT_BIT = FIRST_BIT + irqa_pkg::STAT_OFS;
   localparam logic [31:0] USED_MASK =
      irqa_pkg::field_mask(FIRST_BIT, NUM_SRC) | irqa_pkg::field_mask(STAT_BIT, NUM_SRC);

   generate
      if (NUM_SRC < 1 || FIRST_BIT < 0 || FIRST_BIT + NUM_SRC > irqa_pkg::HALF_W) begin : g_bad_cfg
         $error("irq_agg: enable field must fit in the low register half");
      end
   endgenerate

   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] st_q;

   irqa_edge #(.N(NUM_SRC)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (src_req),
      .rise (rise)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
         irqa_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_en_bit (wr_data[FIRST_BIT + i]),
            .wr_clr_bit(wr_data[STAT_BIT + i]),
            .set       (rise[i]),
            .en_q      (en_q[i]),
            .st_q      (st_q[i])
         );
      end
   endgenerate

   irqa_pack #(.FIRST_BIT(FIRST_BIT), .NUM_SRC(NUM_SRC)) u_pack (
      .en (en_q),
      .st (st_q),
      .rd (rd_data),
      .irq(irq_out)
   );

   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~USED_MASK);
endmodule

// File: rtl/irqa_chk.sv
`timescale 1ns/1ps
module irqa_chk #(
   parameter int FIRST_BIT = 0,
   parameter int NUM_SRC   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic               wr_en,
   input logic [31:0]        wr_data,
   input logic [31:0]        rd_data,
   input logic               irq_out
);
   localparam int SB = FIRST_BIT + irqa_pkg::STAT_OFS;
   localparam logic [31:0] USED =
      irqa_pkg::field_mask(FIRST_BIT, NUM_SRC) | irqa_pkg::field_mask(SB, NUM_SRC);

   logic [NUM_SRC-1:0] seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= src_req;
   end

   // R9: unused bits read zero
   p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~USED) == 32'h0);

   // R7: output level follows enabled and pending sources
   p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == |(rd_data[FIRST_BIT +: NUM_SRC] & rd_data[SB +: NUM_SRC]));

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         // R3
         p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req[i] && !seen_q[i]) |=> rd_data[SB + i]);
         // R4
         p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[SB + i] && !(src_req[i] && !seen_q[i])) |=> !rd_data[SB + i]);
         // R5
         p_w0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[SB + i] && rd_data[SB + i]) |=> rd_data[SB + i]);
         // R2
         p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> rd_data[FIRST_BIT + i] == $past(wr_data[FIRST_BIT + i]));
         p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(rd_data[FIRST_BIT + i]));
      end
   endgenerate
endmodule

bind irq_agg irqa_chk #(.FIRST_BIT(FIRST_BIT), .NUM_SRC(NUM_SRC)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .src_req(src_req),
   .wr_en  (wr_en),
   .wr_data(wr_data),
   .rd_data(rd_data),
   .irq_out(irq_out)
);

// File: tb/tb_irq_agg.sv
`timescale 1ns/1ps
module tb_irq_agg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [6:0]  req = '0;
   logic        we = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic        irq;

   logic [1:0]  req2 = '0;
   logic        we2 = 1'b0;
   logic [31:0] wd2 = '0;
   logic [31:0] rd2;
   logic        irq2;

   irq_agg #(.FIRST_BIT(0), .NUM_SRC(7)) dut (
      .clk(clk), .rst_n(rst_n), .src_req(req), .wr_en(we), .wr_data(wd),
      .rd_data(rd), .irq_out(irq));

   irq_agg #(.FIRST_BIT(4), .NUM_SRC(2)) dut_ofs (
      .clk(clk), .rst_n(rst_n), .src_req(req2), .wr_en(we2), .wr_data(wd2),
      .rd_data(rd2), .irq_out(irq2));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [6:0] m_en = '0, m_st = '0, m_prev = '0;

   function automatic logic [31:0] pack(input logic [6:0] e, input logic [6:0] s);
      return {9'b0, s, 9'b0, e};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, advance one cycle, update model
   task automatic step(input logic [6:0] r, input logic w, input logic [31:0] d);
      logic [6:0] edges;
      req = r; we = w; wd = d;
      @(posedge clk);
      @(negedge clk);
      edges  = r & ~m_prev;
      m_prev = r;
      if (w) begin
         m_en = d[6:0];
         m_st = m_st & ~d[22:16];
      end
      m_st = m_st | edges;
      we = 1'b0;
   endtask

   task automatic step2(input logic [1:0] r, input logic w, input logic [31:0] d);
      req2 = r; we2 = w; wd2 = d;
      @(posedge clk);
      @(negedge clk);
      we2 = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rd", rd, 32'h0);
      chk("R1 reset irq", {31'b0, irq}, 32'h0);

      step(7'h00, 1, 32'h0000_007F);
      chk("R2 enable write", rd, 32'h0000_007F);
      step(7'h00, 0, 32'hFFFF_FFFF);
      chk("R2 enable hold", rd, 32'h0000_007F);
      step(7'h01, 0, 0);
      chk("R3 edge sets", rd, 32'h0001_007F);
      chk("R7 irq up", {31'b0, irq}, 32'h1);
      step(7'h01, 1, 32'h0001_007F);
      chk("R4 w1c", rd, 32'h0000_007F);
      chk("R7 irq down", {31'b0, irq}, 32'h0);
      step(7'h01, 0, 0);
      chk("R3 held level no reset", rd, 32'h0000_007F);
      step(7'h03, 0, 0);
      chk("R3 src1", rd, 32'h0002_007F);
      step(7'h03, 1, 32'h0000_007F);
      chk("R5 w0 keeps", rd, 32'h0002_007F);
      step(7'h07, 1, 32'h0004_007F);
      chk("R6 set wins", rd, 32'h0006_007F);
      step(7'h07, 1, 32'h0006_0000);
      chk("R7 all cleared", {rd[31:1], irq}, 32'h0);
      step(7'h0F, 0, 0);
      chk("R8 latch disabled", rd, 32'h0008_0000);
      chk("R8 irq low", {31'b0, irq}, 32'h0);
      step(7'h0F, 1, 32'h0000_0008);
      chk("R8 enable raises", {rd[31:1], irq}, 32'h0008_0009);
      step(7'h00, 1, 32'hFFFF_FFFF);
      chk("R9 unused zero", rd, 32'h0000_007F);

      for (int n = 0; n < 400; n++) begin
         logic [6:0]  r;
         logic        w;
         logic [31:0] d;
         r = 7'($urandom());
         w = ($urandom() % 4) == 0;
         d = $urandom();
         step(r, w, d);
         chk("R3/R4/R5/R9 model rd", rd, pack(m_en, m_st));
         chk("R7 model irq", {31'b0, irq}, {31'b0, |(m_en & m_st)});
      end

      chk("R1 offset variant idle", rd2, 32'h0);
      step2(2'b00, 1, 32'h0000_0030);
      chk("R10 offset enables", rd2, 32'h0000_0030);
      step2(2'b01, 0, 0);
      chk("R10 src0 to bit20", {rd2[31:1], irq2}, 32'h0010_0031);
      step2(2'b01, 1, 32'hFFFF_FFFF);
      chk("R10 R9 offset wr all", rd2, 32'h0000_0030);
      step2(2'b11, 0, 0);
      chk("R10 src1 to bit21", rd2, 32'h0020_0030);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule